// File: doc/BRIEF.md
# Firmware Region Write Guard

This block guards writes to the firmware flash region. It holds one 16-bit control word with two live fields: a write-enable flag and a lock flag. Software updates the word through a small select/write/read port. Every firmware-space cycle that arrives is checked against the stored write-enable flag. Reads always pass. Writes pass only while the flag is set.

The lock flag works as a one-way latch. Software can set it, but only the synchronous platform reset clears it. If software raises the write-enable flag while the lock is in effect, the block emits a one-cycle management-interrupt request. Firmware running in management mode can then decide whether the update is legitimate.

Top module: `fwp_guard`

## Requirements
- R1: After a cycle with `rst` high, `reg_rdata` reads 0x0000 and `smi_req` is 0.
- R2: Control word bits 15:2 always read as zero, and writing ones to them changes nothing visible on `reg_rdata`.
- R3: While write-enable (bit 0) reads 0, a valid cycle with `cyc_write`=0 (read) gives `fwd_ok`=1 and a valid cycle with `cyc_write`=1 (write) gives `fwd_ok`=0, in the same cycle.
- R4: While write-enable (bit 0) reads 1, valid read and write cycles both give `fwd_ok`=1 in the same cycle.
- R5: `fwd_ok` is 0 whenever `cyc_valid` is 0.
- R6: A write accepted at a clock edge (`reg_sel`=1, `reg_wr`=1) that changes bit 0 from 0 to 1 while bit 1 is 1 after the write raises `smi_req` in the cycle after that edge. This includes a write that sets bits 1 and 0 together.
- R7: `smi_req` stays 0 when bit 0 rises with bit 1 clear, and when bit 0 is written to 1 while it already reads 1.
- R8: Once bit 1 (lock) reads 1, writing 0 to it leaves it at 1. Only `rst` returns it to 0.
- R9: A register write with `reg_sel`=0 leaves `reg_rdata` unchanged.
- R10: `smi_req` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high platform reset |
| reg_sel | input | 1 | Control word is addressed |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current control word |
| cyc_valid | input | 1 | A firmware-space cycle is presented |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| fwd_ok | output | 1 | Cycle may be forwarded to the flash interface |
| smi_req | output | 1 | One-cycle management-interrupt request |

## Verification
`fwd_ok` is combinational. It depends on the presented cycle and the stored write-enable flag, so it is due in the same cycle as its inputs. A control word write shows on `reg_rdata` one edge later. `smi_req` comes from the same edge and is high for exactly the cycle after it. The bench drives inputs on the falling edge and checks all three outputs shortly afterwards against a behavioural model. It advances the model only at the rising edge, so each result is compared in the cycle it is due.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

    localparam int unsigned CTRL_W   = 16;
    localparam int unsigned WREN_POS = 0;
    localparam int unsigned LOCK_POS = 1;

    // bits software may write; everything else is reserved
    localparam logic [CTRL_W-1:0] WR_MASK =
        (CTRL_W'(1) << WREN_POS) | (CTRL_W'(1) << LOCK_POS);

    typedef enum logic {
        CYC_RD = 1'b0,
        CYC_WR = 1'b1
    } cyc_kind_e;

    typedef struct packed {
        logic      valid;
        cyc_kind_e kind;
    } cyc_req_t;

    typedef struct packed {
        logic lock;
        logic wren;
    } ctrl_t;

    function automatic ctrl_t ctrl_view(logic [CTRL_W-1:0] word);
        ctrl_t c;
        c.lock = word[LOCK_POS];
        c.wren = word[WREN_POS];
        return c;
    endfunction

    // next word for an accepted write: reserved bits dropped, lock sticky
    function automatic logic [CTRL_W-1:0] ctrl_next(logic [CTRL_W-1:0] cur,
                                                    logic [CTRL_W-1:0] wd);
        logic [CTRL_W-1:0] n;
        n = wd & WR_MASK;
        n[LOCK_POS] = n[LOCK_POS] | cur[LOCK_POS];
        return n;
    endfunction

    function automatic logic smi_cond(ctrl_t prev, ctrl_t nxt);
        return nxt.wren & ~prev.wren & nxt.lock;
    endfunction

endpackage

// File: rtl/fwp_ctrl_reg.sv
module fwp_ctrl_reg
    import fwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_acc,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] word_q,
    output logic              smi_q
);
    logic [CTRL_W-1:0] word_d;
    logic              smi_d;

    always_comb begin
        word_d = word_q;
        smi_d  = 1'b0;
        if (wr_acc) begin
            word_d = ctrl_next(word_q, wdata);
            smi_d  = smi_cond(ctrl_view(word_q), ctrl_view(word_d));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            smi_q  <= 1'b0;
        end else begin
            word_q <= word_d;
            smi_q  <= smi_d;
        end
    end
endmodule

// File: rtl/fwp_fwd_gate.sv
module fwp_fwd_gate
    import fwp_pkg::*;
(
    input  cyc_req_t req,
    input  ctrl_t    ctrl,
    output logic     ok
);
    always_comb begin
        ok = 1'b0;
        if (req.valid) begin
            unique case (req.kind)
                CYC_RD: ok = 1'b1;
                CYC_WR: ok = ctrl.wren;
                default: ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/fwp_guard.sv
module fwp_guard
    import fwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              cyc_valid,
    input  logic              cyc_write,
    output logic              fwd_ok,
    output logic              smi_req
);
    logic [CTRL_W-1:0] word_q;
    cyc_req_t          req;
    ctrl_t             ctrl;

    assign req.valid = cyc_valid;
    assign req.kind  = cyc_write ? CYC_WR : CYC_RD;
    assign ctrl      = ctrl_view(word_q);
    assign reg_rdata = word_q;

    fwp_ctrl_reg u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_acc (reg_sel & reg_wr),
        .wdata  (reg_wdata),
        .word_q (word_q),
        .smi_q  (smi_req)
    );

    fwp_fwd_gate u_gate (
        .req  (req),
        .ctrl (ctrl),
        .ok   (fwd_ok)
    );
endmodule

// File: rtl/fwp_guard_chk.sv
module fwp_guard_chk
    import fwp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_sel,
    input logic [CTRL_W-1:0] reg_rdata,
    input logic              cyc_valid,
    input logic              cyc_write,
    input logic              fwd_ok,
    input logic              smi_req
);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~WR_MASK) == '0);

    // R3
    wr_block_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_write && !reg_rdata[WREN_POS]) |-> !fwd_ok);

    // R4
    wr_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && reg_rdata[WREN_POS]) |-> fwd_ok);

    // R5
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |-> !fwd_ok);

    // R6
    smi_src_chk: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> (reg_rdata[WREN_POS] && reg_rdata[LOCK_POS]));

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[LOCK_POS] |=> reg_rdata[LOCK_POS]);

    // R9
    unsel_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |=> $stable(reg_rdata));

    // R10
    smi_single_chk: assert property (@(posedge clk) disable iff (rst)
        smi_req |=> !smi_req);
endmodule

bind fwp_guard fwp_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .cyc_valid (cyc_valid),
    .cyc_write (cyc_write),
    .fwd_ok    (fwd_ok),
    .smi_req   (smi_req)
);

// File: tb/fwp_guard_bench.sv
module fwp_guard_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cyc_valid = 1'b0;
    logic        cyc_write = 1'b0;
    logic        fwd_ok;
    logic        smi_req;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    // behavioural reference state
    int m_wren = 0;
    int m_lock = 0;
    int m_smi  = 0;

    always #4 clk = ~clk;

    fwp_guard u_fwp_guard (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cyc_valid(cyc_valid), .cyc_write(cyc_write),
        .fwd_ok(fwd_ok), .smi_req(smi_req)
    );

    task automatic compare(string tag);
        int exp_rd;
        int exp_ok;
        exp_rd = m_lock * 2 + m_wren;
        exp_ok = (cyc_valid && (!cyc_write || m_wren != 0)) ? 1 : 0;
        vectors++;
        if (reg_rdata !== 16'(exp_rd)) begin
            miscompares++;
            $display("FAIL %s reg_rdata actual=%h expected=%h", tag, reg_rdata, 16'(exp_rd));
        end
        vectors++;
        if (fwd_ok !== 1'(exp_ok)) begin
            miscompares++;
            $display("FAIL %s fwd_ok actual=%b expected=%0d", tag, fwd_ok, exp_ok);
        end
        vectors++;
        if (smi_req !== 1'(m_smi)) begin
            miscompares++;
            $display("FAIL %s smi_req actual=%b expected=%0d", tag, smi_req, m_smi);
        end
    endtask

    // apply inputs, check this cycle, then advance the model across the edge
    task automatic step(string tag, bit r, bit sel, bit wr, logic [15:0] wd,
                        bit cv, bit cw);
        int nw;
        int nl;
        rst = r; reg_sel = sel; reg_wr = wr; reg_wdata = wd;
        cyc_valid = cv; cyc_write = cw;
        #1;
        compare(tag);
        @(posedge clk);
        if (r) begin
            m_wren = 0; m_lock = 0; m_smi = 0;
        end else if (sel && wr) begin
            nw = wd[0] ? 1 : 0;
            nl = (wd[1] || m_lock != 0) ? 1 : 0;
            m_smi  = (nw == 1 && m_wren == 0 && nl == 1) ? 1 : 0;
            m_wren = nw;
            m_lock = nl;
        end else begin
            m_smi = 0;
        end
        @(negedge clk);
    endtask

    task automatic wreg(string tag, logic [15:0] wd);
        step(tag, 0, 1, 1, wd, 0, 0);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 16'h0000, 0, 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (2) @(negedge clk);
        // R1 reset state
        step("R1", 1, 0, 0, 16'h0000, 0, 0);
        idle("R1");
        // R2 reserved bits
        wreg("R2", 16'hFFFC);
        idle("R2");
        // R5 no cycle presented
        step("R5", 0, 0, 0, 16'h0000, 0, 1);
        // R3 write-enable clear
        step("R3", 0, 0, 0, 16'h0000, 1, 0);
        step("R3", 0, 0, 0, 16'h0000, 1, 1);
        // R9 unselected write
        step("R9", 0, 0, 1, 16'h0003, 0, 0);
        idle("R9");
        // R7 rise without lock, then rewrite while set
        wreg("R7", 16'h0001);
        idle("R7");
        wreg("R7", 16'h0001);
        idle("R7");
        // R4 both directions pass
        step("R4", 0, 0, 0, 16'h0000, 1, 1);
        step("R4", 0, 0, 0, 16'h0000, 1, 0);
        step("R5", 0, 0, 0, 16'h0000, 0, 1);
        // arm lock with write-enable cleared
        wreg("R8", 16'h0002);
        wreg("R8", 16'h0000);
        idle("R8");
        // R6 rise under lock, R10 single pulse
        wreg("R6", 16'h0001);
        idle("R10");
        idle("R10");
        wreg("R7", 16'h0003);
        idle("R7");
        wreg("R6", 16'h0002);
        wreg("R6", 16'h0003);
        wreg("R10", 16'h0000);
        wreg("R6", 16'h0001);
        idle("R10");
        // R8 reset clears lock
        step("R8", 1, 0, 0, 16'h0000, 0, 0);
        idle("R8");
        // R6 lock and write-enable set together
        wreg("R6", 16'h0003);
        idle("R10");
        step("R1", 1, 0, 0, 16'h0000, 0, 0);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            step("R3", ($urandom % 50) == 0, $urandom % 2, $urandom % 2,
                 16'($urandom), $urandom % 2, $urandom % 2);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule